// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers event pulses from nearby peripherals (a timer compare match, a serial character arriving, a serial character leaving, and five spare lines) into an 8-bit pending bitmap. A second 8-bit bitmap chooses which pending bits may interrupt the processor. Any bit that is both pending and enabled pulls a single active-low request line low. There is no ranking between sources.

Software uses a plain single-cycle register port. It reads the pending bitmap to find which source raised the request. It clears a pending bit by writing 0 to that bit position, and writing 1 leaves the bit as it is. It sets the enable bitmap by writing it, and can read it back. The request line comes from a flop, so it moves only on a clock edge, one cycle after the bitmaps that feed it.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, the pending bitmap and the enable bitmap both read 0 and `irq_n` is 1.
- R2: Pending bit i is set on the cycle after `src_evt[i]` is seen going from 0 to 1. The bit positions are: bit 0 timer compare match, bit 1 receive character ready, bit 2 transmit ready, bits 3 to 7 spare. A source held high sets its bit only once, and does not set it again after the bit is cleared.
- R3: A pending bit stays set until software clears it. A write to offset 0x18 clears each bit where the write data holds 0, and leaves each bit where the write data holds 1.
- R4: When a rising edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: The enable bitmap at offset 0x1C takes the full write data and reads back the last value written.
- R6: `irq_n` is 0 in a cycle exactly when, in the cycle before, the bitwise AND of the pending and enable bitmaps was nonzero.
- R7: A read (`bus_sel`=1, `bus_we`=0) returns in the same cycle the pending bitmap at 0x18, the enable bitmap at 0x1C, and 0 at any other offset. Writes to any other offset change nothing. `bus_rdata` is 0 when no read is taking place.
- R8: Masking affects only the request line. A pending bit whose enable bit is 0 still latches, and it raises the request as soon as it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | 8 | Event lines from the sources, one per pending bit |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle as the read |
| irq_n | output | 1 | Interrupt request, active low, driven from a flop |

## Verification
The assertions assume that the event lines and the bus inputs change only between clock edges and stay steady around each rising edge. They also assume that any value on an unused offset is harmless. The bench drives every input on the falling edge, so it keeps within these assumptions. It mixes random event bursts, random reads and writes (including writes to unused offsets) with directed cases: a source held high across a clear, a clear that meets an edge in the same cycle, and a source that latches while it is masked.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 8;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h1C;
  localparam int BIT_TIMER = 0;
  localparam int BIT_RXRDY = 1;
  localparam int BIT_TXRDY = 2;
endpackage

// File: rtl/irq_edge_catch.sv
module irq_edge_catch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end

  // R2: an edge needs the line low in the cycle before
  assert_edge_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise & $past(lvl)) == '0));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] keep_mask,
  output logic [W-1:0] pend
);
  logic [W-1:0] pend_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pend_q[i] <= 1'b0;
      else if (set_i[i])               pend_q[i] <= 1'b1;
      else if (clr_en && !keep_mask[i]) pend_q[i] <= 1'b0;
    end
  end
  assign pend = pend_q;

  // R4: a set always lands, even when a clear arrives in the same cycle
  assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend & $past(set_i)) == $past(set_i)));
  // R3: without a clearing write no pending bit drops
  assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((pend & $past(pend)) == $past(pend)));
  // R3: a bit written as 1 is never dropped
  assert_keep_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((pend & $past(pend & keep_mask)) == $past(pend & keep_mask)));
endmodule

// File: rtl/irq_req_drive.sv
module irq_req_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] mask,
  output logic         req_n
);
  logic        req_n_q;
  logic [W-1:0] live;

  assign live = pend & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_n_q <= 1'b1;
    else        req_n_q <= ~(|live);
  end
  assign req_n = req_n_q;

  // R6: an enabled pending bit pulls the request low one cycle later
  assert_req_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & mask) != '0) |=> !req_n);
  // R6: no enabled pending bit releases the request one cycle later
  assert_req_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & mask) == '0) |=> req_n);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  src_evt,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_n
);
  logic [REG_W-1:0] rise;
  logic [REG_W-1:0] pend;
  logic [REG_W-1:0] mask_q;
  logic             wr_pend, wr_mask, rd;

  assign wr_pend = bus_sel && bus_we && (bus_addr == OFS_PEND);
  assign wr_mask = bus_sel && bus_we && (bus_addr == OFS_MASK);
  assign rd      = bus_sel && !bus_we;

  irq_edge_catch #(.W(REG_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(src_evt), .rise(rise));

  irq_pend_bank #(.W(REG_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(rise), .clr_en(wr_pend),
    .keep_mask(bus_wdata), .pend(pend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr == OFS_PEND)      bus_rdata = pend;
      else if (bus_addr == OFS_MASK) bus_rdata = mask_q;
    end
  end

  irq_req_drive #(.W(REG_W)) u_req (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask_q), .req_n(irq_n));

  // R7: writes to other offsets leave the enable bitmap alone
  assert_stray_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr != OFS_MASK) |=> $stable(mask_q));
  // R5: an enable write lands as written
  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(bus_wdata)));
endmodule

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_evt = '0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_n;

  int errors = 0, checks = 0;
  logic [7:0] m_pend = '0, m_mask = '0, m_prev = '0;
  logic       m_irq_n = 1'b1;

  always #2 clk = ~clk;

  irq_mask_ctrl dut (.clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n));

  function automatic logic [7:0] exp_read(logic sel, logic we, logic [7:0] a);
    if (!sel || we) return 8'h00;
    if (a == 8'h18) return m_pend;
    if (a == 8'h1C) return m_mask;
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [7:0] s, logic sel, logic we, logic [7:0] a, logic [7:0] wd,
                     string rtag);
    logic [7:0] rise;
    @(negedge clk);
    src_evt = s; bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    #1;
    if (sel && !we) check(rtag, bus_rdata, exp_read(sel, we, a));
    @(posedge clk);
    rise = s & ~m_prev;
    m_prev = s;
    m_irq_n = ~(|(m_pend & m_mask));
    if (sel && we && a == 8'h18) m_pend = m_pend & wd;
    if (sel && we && a == 8'h1C) m_mask = wd;
    m_pend = m_pend | rise;
    #1;
    check("R6 irq_n", {7'b0, irq_n}, {7'b0, m_irq_n});
  endtask

  task automatic rd(logic [7:0] a, string tag);
    cyc(m_prev, 1'b1, 1'b0, a, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    #5;
    check("R1 pend", dut.bus_rdata, 8'h00);
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    rst_n = 1'b1;
    rd(8'h18, "R1 pending after reset");
    rd(8'h1C, "R1 enable after reset");
    // R5: enable write and read back
    cyc(8'h00, 1, 1, 8'h1C, 8'h07, "");
    rd(8'h1C, "R5 enable readback");
    // R2: timer, rx, tx positions
    cyc(8'h01, 0, 0, 0, 0, ""); cyc(8'h00, 0, 0, 0, 0, "");
    rd(8'h18, "R2 timer bit0");
    cyc(8'h06, 0, 0, 0, 0, "");
    rd(8'h18, "R2 rx/tx bits");
    // R3: writing 1 keeps, 0 clears
    cyc(8'h06, 1, 1, 8'h18, 8'hFB, "");
    rd(8'h18, "R3 partial clear");
    // R2: held-high source does not re-set
    cyc(8'h06, 1, 1, 8'h18, 8'h00, "");
    cyc(8'h06, 0, 0, 0, 0, ""); cyc(8'h06, 0, 0, 0, 0, "");
    rd(8'h18, "R2 held level no reset");
    // R4: edge and clear together
    cyc(8'h00, 0, 0, 0, 0, "");
    cyc(8'h10, 1, 1, 8'h18, 8'h00, "");
    rd(8'h18, "R4 event wins");
    // R8: masked bit latches, then raises request when enabled
    cyc(8'h00, 1, 1, 8'h1C, 8'h00, "");
    cyc(8'h80, 0, 0, 0, 0, ""); cyc(8'h00, 0, 0, 0, 0, "");
    rd(8'h18, "R8 masked latch");
    cyc(8'h00, 1, 1, 8'h1C, 8'h80, "");
    cyc(8'h00, 0, 0, 0, 0, ""); cyc(8'h00, 0, 0, 0, 0, "");
    // R7: stray offsets
    cyc(8'h00, 1, 1, 8'h20, 8'hFF, "");
    cyc(8'h00, 1, 1, 8'h19, 8'h00, "");
    rd(8'h20, "R7 stray read");
    rd(8'h1C, "R7 enable unchanged");
    rd(8'h18, "R7 pending unchanged");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] s, a, wd;
      int r;
      s = m_prev;
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 9) == 0) s[b] = ~s[b];
      r = $urandom_range(0, 5);
      case ($urandom_range(0, 3))
        0: a = 8'h18; 1: a = 8'h1C; 2: a = 8'h18; default: a = 8'($urandom_range(0, 63));
      endcase
      wd = 8'($urandom);
      cyc(s, r < 4, r < 2, a, wd, "R7 random read");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule